// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

This block watches a processor through a small register bus. Once software enables it, an internal counter climbs one step per clock. Software must restart that counter by writing a restart register before it reaches a programmed limit. If the limit is reached, the block forces a hard reset. That hard reset cannot be switched off and cannot be replaced by anything softer. In warning mode, the block first raises an interrupt so that software can save diagnostic data. Exactly 512 cycles later it asserts the hard reset anyway, unless a restart arrives inside that interval.

The control and limit registers are guarded. A write to either of them takes effect only during a short access window. The window opens when two key values are written to a key register in two consecutive clock cycles. Once the enable bit is set, software cannot clear it and cannot change the mode. Only the end of a watchdog reset, or the external reset pin, returns the control register to its defaults.

A status register records why the last reset happened: the external pin or the watchdog. Each flag stays set until software writes a one to it.

Top module: `wdg_guard`

## Requirements
- R1: After the external pin reset (`rst_pin_n` low), `wd_irq` and `wd_rst` are low. CTRL (address 2) reads 0. LIMIT (address 3) reads the default 16'h0100. STATUS (address 4) reads 2: bit1 is the pin-cause flag and reads 1, bit0 is the watchdog-cause flag and reads 0.
- R2: The access window opens only when 16'h00AA and then 16'h0055 are written to KEY (address 1) in two consecutive cycles. An idle cycle between them aborts the sequence. So does a write to any other address, or a different value written to KEY.
- R3: A write to CTRL or LIMIT takes effect only in the first, second or third cycle after the 16'h0055 key write. In any other cycle it is ignored, and the register keeps its value.
- R4: CTRL bit0 is the enable and CTRL bit1 selects warning mode. While enable is 1, any write to CTRL is ignored, even inside an open window. LIMIT stays writable under the window.
- R5: Let L be the limit value. If the last write to RESTART (address 0, any data) or the enabling CTRL write is made at clock edge e, the timeout outcome appears at edge e+L+1.
- R6: In warning mode the timeout raises `wd_irq`. `wd_rst` rises exactly 512 cycles after `wd_irq` rises. A RESTART write before then drops `wd_irq` at that edge and starts a new count.
- R7: With CTRL bit1 = 0, the timeout asserts `wd_rst` directly, and `wd_irq` stays low.
- R8: `wd_rst` stays high for exactly 16 cycles. When it falls, CTRL returns to 0 and LIMIT returns to 16'h0100.
- R9: STATUS bit0 is set when the watchdog asserts `wd_rst`. Writing 1 to a STATUS bit clears that bit. Otherwise each STATUS bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| wd_irq | output | 1 | Early-warning interrupt |
| wd_rst | output | 1 | Hard reset to the processor |

## Verification
The bench attacks the unlock sequence with an idle cycle, a foreign write and a wrong key value placed between the two key writes. A design that only looks for the two key values in order, without requiring consecutive cycles, would accept all three. It probes the window at both edges: a write in the third cycle after the key must land and one in the fourth must not, so an off-by-one window shows up as a wrong LIMIT readback. Random limits and modes measure the cycle count from restart to timeout, from interrupt to reset, and the reset width. These expose a counter that compares one step early or late, or a grace period that a late restart fails to cancel. An attempt to clear the enable while it is set catches a watchdog that software could switch off.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_WARN = 2'd1,
      PH_BITE = 2'd2
   } wdg_phase_e;

   localparam int unsigned A_RESTART = 0;
   localparam int unsigned A_KEY     = 1;
   localparam int unsigned A_CTRL    = 2;
   localparam int unsigned A_LIMIT   = 3;
   localparam int unsigned A_STATUS  = 4;

endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned OPEN_CYC = 3,
   parameter logic [DATA_W-1:0] KEY_A = 'hAA,
   parameter logic [DATA_W-1:0] KEY_B = 'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              open_o
);

   logic first_q;
   logic arm;

   initial begin
      a_cfg_open: assert (OPEN_CYC >= 1) else $error("OPEN_CYC must be at least 1");
      a_cfg_keys: assert (KEY_A != KEY_B) else $error("keys must differ");
   end

   // first key seen in the cycle just before; any other cycle drops it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b0;
      else        first_q <= key_wr_i && (wdata_i == KEY_A);
   end

   assign arm = first_q && key_wr_i && (wdata_i == KEY_B);

   generate
      if (OPEN_CYC == 1) begin : g_flag
         logic win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win_q <= 1'b0;
            else        win_q <= arm;
         end
         assign open_o = win_q;
      end else begin : g_count
         localparam int unsigned WW = $clog2(OPEN_CYC + 1);
         logic [WW-1:0] win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              win_q <= '0;
            else if (arm)            win_q <= WW'(OPEN_CYC);
            else if (win_q != '0)    win_q <= win_q - 1'b1;
         end
         assign open_o = (win_q != '0);
      end
   endgenerate

   // R2: the window can only open right after the second key write
   a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(key_wr_i && (wdata_i == KEY_B)));

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned GRACE_CYC = 512,
   parameter int unsigned HOLD_CYC  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             warn_mode_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             restart_i,
   output logic             irq_o,
   output logic             bite_o,
   output logic             bite_start_o,
   output logic             bite_done_o
);

   localparam int unsigned GW = $clog2(GRACE_CYC);
   localparam int unsigned HW = $clog2(HOLD_CYC);

   wdg_phase_e     phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [GW-1:0]    grace_q;
   logic [HW-1:0]    hold_q;
   logic             expire;
   logic             grace_end;

   initial begin
      a_cfg_grace: assert (GRACE_CYC >= 2) else $error("GRACE_CYC too small");
      a_cfg_hold:  assert (HOLD_CYC >= 2)  else $error("HOLD_CYC too small");
   end

   assign expire      = (phase_q == PH_RUN) && en_i && !restart_i && (cnt_q == limit_i);
   assign grace_end   = (phase_q == PH_WARN) && !restart_i && (grace_q == GW'(GRACE_CYC - 1));
   assign bite_start_o = (expire && !warn_mode_i) || grace_end;
   assign bite_done_o  = (phase_q == PH_BITE) && (hold_q == HW'(HOLD_CYC - 1));
   assign irq_o        = (phase_q == PH_WARN);
   assign bite_o       = (phase_q == PH_BITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         cnt_q   <= '0;
         grace_q <= '0;
         hold_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_RUN: begin
               if (!en_i || restart_i) begin
                  cnt_q <= '0;
               end else if (expire) begin
                  cnt_q <= '0;
                  if (warn_mode_i) begin
                     phase_q <= PH_WARN;
                     grace_q <= '0;
                  end else begin
                     phase_q <= PH_BITE;
                     hold_q  <= '0;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_WARN: begin
               if (restart_i) begin
                  phase_q <= PH_RUN;
                  cnt_q   <= '0;
               end else if (grace_end) begin
                  phase_q <= PH_BITE;
                  hold_q  <= '0;
               end else begin
                  grace_q <= grace_q + 1'b1;
               end
            end
            PH_BITE: begin
               if (bite_done_o) begin
                  phase_q <= PH_RUN;
                  cnt_q   <= '0;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            default: phase_q <= PH_RUN;
         endcase
      end
   end

   // R6: once warned, only a restart can avoid the hard reset
   a_r6_warn_leads_bite: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !restart_i) |=> (irq_o || bite_o));
   // R7: direct mode never raises the warning
   a_r7_direct_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RUN && !warn_mode_i) |=> !irq_o);
   // R8: the reset pulse is not cut short
   a_r8_bite_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bite_o && !bite_done_o) |=> bite_o);
   // R5: a restart outside the reset pulse clears any pending outcome
   a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && !bite_o) |=> (!irq_o && !bite_o));

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 16,
   parameter logic [CNT_W-1:0] LIMIT_INIT = 'h0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              open_i,
   input  logic              bite_start_i,
   input  logic              bite_done_i,
   output logic              en_o,
   output logic              warn_mode_o,
   output logic [CNT_W-1:0]  limit_o,
   output logic [DATA_W-1:0] rdata_o
);

   logic en_q, mode_q, wd_cause_q, pin_cause_q;
   logic [CNT_W-1:0] limit_q;
   logic wr_ctrl, wr_limit, wr_stat;

   initial begin
      a_cfg_width: assert (CNT_W <= DATA_W && DATA_W >= 8) else $error("bad widths");
      a_cfg_addr:  assert (ADDR_W >= 3) else $error("ADDR_W too small");
   end

   assign wr_ctrl  = wr_i && (addr_i == ADDR_W'(A_CTRL));
   assign wr_limit = wr_i && (addr_i == ADDR_W'(A_LIMIT));
   assign wr_stat  = wr_i && (addr_i == ADDR_W'(A_STATUS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_q  <= 1'b0;
         limit_q <= LIMIT_INIT;
      end else if (bite_done_i) begin
         en_q    <= 1'b0;
         mode_q  <= 1'b0;
         limit_q <= LIMIT_INIT;
      end else begin
         if (wr_ctrl && open_i && !en_q) begin
            en_q   <= wdata_i[0];
            mode_q <= wdata_i[1];
         end
         if (wr_limit && open_i) limit_q <= wdata_i[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_cause_q  <= 1'b0;
         pin_cause_q <= 1'b1;
      end else begin
         if (bite_start_i)                 wd_cause_q  <= 1'b1;
         else if (wr_stat && wdata_i[0])   wd_cause_q  <= 1'b0;
         if (wr_stat && wdata_i[1])        pin_cause_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         ADDR_W'(A_KEY):    rdata_o[0]       = open_i;
         ADDR_W'(A_CTRL):   rdata_o[1:0]     = {mode_q, en_q};
         ADDR_W'(A_LIMIT):  rdata_o[CNT_W-1:0] = limit_q;
         ADDR_W'(A_STATUS): rdata_o[1:0]     = {pin_cause_q, wd_cause_q};
         default:           rdata_o          = '0;
      endcase
   end

   assign en_o        = en_q;
   assign warn_mode_o = mode_q;
   assign limit_o     = limit_q;

   // R3: the limit moves only inside the window or at the end of a reset
   a_r3_limit_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_i && !bite_done_i) |=> $stable(limit_q));
   // R4: software cannot turn the watchdog off
   a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !bite_done_i) |=> en_q);
   // R9: the watchdog cause flag holds until software clears it
   a_r9_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_cause_q && !(wr_stat && wdata_i[0])) |=> wd_cause_q);

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned OPEN_CYC  = 3,
   parameter int unsigned GRACE_CYC = 512,
   parameter int unsigned HOLD_CYC  = 16,
   parameter logic [DATA_W-1:0] KEY_A = 'hAA,
   parameter logic [DATA_W-1:0] KEY_B = 'h55,
   parameter logic [CNT_W-1:0]  LIMIT_INIT = 'h0100
) (
   input  logic              clk,
   input  logic              rst_pin_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wd_irq,
   output logic              wd_rst
);

   logic wr_ok, key_wr, restart, open;
   logic en, warn_mode, bite_start, bite_done;
   logic [CNT_W-1:0] limit;

   // the processor is held in reset during the pulse: its bus is ignored
   assign wr_ok   = bus_we && !wd_rst;
   assign key_wr  = wr_ok && (bus_addr == ADDR_W'(A_KEY));
   assign restart = wr_ok && (bus_addr == ADDR_W'(A_RESTART));

   wdg_unlock #(
      .DATA_W(DATA_W), .OPEN_CYC(OPEN_CYC), .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) unlock_i (
      .clk(clk), .rst_n(rst_pin_n), .key_wr_i(key_wr),
      .wdata_i(bus_wdata), .open_o(open)
   );

   wdg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LIMIT_INIT(LIMIT_INIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_pin_n), .wr_i(wr_ok), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .open_i(open), .bite_start_i(bite_start),
      .bite_done_i(bite_done), .en_o(en), .warn_mode_o(warn_mode),
      .limit_o(limit), .rdata_o(bus_rdata)
   );

   wdg_timer #(
      .CNT_W(CNT_W), .GRACE_CYC(GRACE_CYC), .HOLD_CYC(HOLD_CYC)
   ) timer_i (
      .clk(clk), .rst_n(rst_pin_n), .en_i(en), .warn_mode_i(warn_mode),
      .limit_i(limit), .restart_i(restart), .irq_o(wd_irq), .bite_o(wd_rst),
      .bite_start_o(bite_start), .bite_done_o(bite_done)
   );

   // R8: a hard reset pulse always ends with the watchdog disarmed
   a_r8_disarm_after_bite: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $fell(wd_rst) |-> !en);

endmodule

// File: tb/wdg_guard_tb_top.sv
module wdg_guard_tb_top;

   localparam int unsigned LIM0 = 16'h0100;

   logic clk = 1'b0;
   logic rst_pin_n;
   logic bus_we;
   logic [2:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic wd_irq, wd_rst;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdg_guard dut_i (
      .clk(clk), .rst_pin_n(rst_pin_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_irq(wd_irq), .wd_rst(wd_rst)
   );

   function automatic int exp_timeout(int lim);
      return lim + 1;
   endfunction

   function automatic logic [15:0] exp_ctrl(bit mode, bit en);
      return {14'd0, mode, en};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one write at a falling edge; it lands on the next rising edge
   task automatic put(logic [2:0] a, logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      bus_we = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic unlock();
      put(3'd1, 16'h00AA);
      put(3'd1, 16'h0055);
   endtask

   // count falling edges until the chosen output goes high
   task automatic wait_hi(bit sel_rst, output int k, output bit irq_seen);
      k = 0; irq_seen = 0;
      bus_we = 1'b0;
      while (k < 4000 && !(sel_rst ? wd_rst : wd_irq)) begin
         @(negedge clk);
         k++;
         if (wd_irq) irq_seen = 1;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int k, lim, n;
      bit mode, seen;
      void'($urandom(32'd4242));
      bus_we = 0; bus_addr = 0; bus_wdata = 0;
      rst_pin_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_pin_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", wd_irq, 0);
      check("R1 rst", wd_rst, 0);
      rd(3'd2, d); check("R1 ctrl", d, 0);
      rd(3'd3, d); check("R1 limit", d, LIM0);
      rd(3'd4, d); check("R1 status", d, 2);

      // R9 clear pin cause
      put(3'd4, 16'h0002); idle(1);
      rd(3'd4, d); check("R9 clear pin flag", d, 0);

      // R2 proper sequence
      unlock(); put(3'd3, 16'h0011); idle(1);
      rd(3'd3, d); check("R2 good key opens", d, 16'h0011);
      // R2 idle gap aborts
      put(3'd1, 16'h00AA); idle(1); put(3'd1, 16'h0055); put(3'd3, 16'h0022); idle(1);
      rd(3'd3, d); check("R2 idle gap", d, 16'h0011);
      // R2 foreign write aborts
      put(3'd1, 16'h00AA); put(3'd4, 16'h0000); put(3'd1, 16'h0055); put(3'd3, 16'h0023); idle(1);
      rd(3'd3, d); check("R2 foreign write", d, 16'h0011);
      // R2 wrong key value aborts
      put(3'd1, 16'h00AA); put(3'd1, 16'h0012); put(3'd1, 16'h0055); put(3'd3, 16'h0024); idle(1);
      rd(3'd3, d); check("R2 wrong value", d, 16'h0011);
      // R2 repeated first key still valid
      put(3'd1, 16'h00AA); unlock(); put(3'd3, 16'h0025); idle(1);
      rd(3'd3, d); check("R2 double first key", d, 16'h0025);
      // R3 third cycle accepted
      unlock(); idle(2); put(3'd3, 16'h0026); idle(1);
      rd(3'd3, d); check("R3 third cycle", d, 16'h0026);
      // R3 fourth cycle rejected
      unlock(); idle(3); put(3'd3, 16'h0027); idle(1);
      rd(3'd3, d); check("R3 fourth cycle", d, 16'h0026);
      // R3 control without unlock
      put(3'd2, 16'h0001); idle(1);
      rd(3'd2, d); check("R3 ctrl locked", d, 0);

      for (int t = 0; t < 10; t++) begin
         lim  = $urandom_range(8, 60);
         mode = (t < 2) ? t[0] : 1'($urandom_range(0, 1));
         unlock(); put(3'd3, 16'(lim)); put(3'd2, exp_ctrl(mode, 1'b1));
         rd(3'd2, d); check("R4 ctrl set", d, exp_ctrl(mode, 1'b1));
         unlock(); put(3'd2, 16'h0000);
         rd(3'd2, d); check("R4 disable ignored", d, exp_ctrl(mode, 1'b1));
         put(3'd0, 16'h0000);
         wait_hi(!mode, k, seen);
         check("R5 timeout cycles", k, exp_timeout(lim));
         if (mode) begin
            if ($urandom_range(0, 1) == 1) begin
               n = $urandom_range(1, 400);
               idle(n); put(3'd0, 16'h0000);
               check("R6 restart drops irq", wd_irq, 0);
               wait_hi(1'b0, k, seen);
               check("R5 timeout after late restart", k, exp_timeout(lim));
            end
            wait_hi(1'b1, k, seen);
            check("R6 grace length", k, 512);
         end else begin
            check("R7 no irq", {31'd0, seen | wd_irq}, 0);
         end
         k = 0;
         while (wd_rst && k < 100) begin @(negedge clk); k++; end
         check("R8 pulse width", k, 16);
         rd(3'd2, d); check("R8 ctrl default", d, 0);
         rd(3'd3, d); check("R8 limit default", d, LIM0);
         rd(3'd4, d); check("R9 wd flag set", d, 1);
         put(3'd4, 16'h0001); idle(1);
         rd(3'd4, d); check("R9 wd flag clear", d, 0);
      end

      // R1 pin reset again
      rst_pin_n = 1'b0; #2; rst_pin_n = 1'b1;
      @(negedge clk);
      rd(3'd4, d); check("R1 pin cause", d, 2);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule